// File: doc/BRIEF.md
# Parallel Pseudorandom Word Generator

This block emits a pseudorandom test pattern as a parallel word, one word per clock, for a serializer further down the path. Each word carries the next WORD_W consecutive bits of a maximal-length binary sequence. All WORD_W serial shift steps are folded into one combinational next-state function, so no clock at the bit rate is needed inside the block.

A 3-bit mode input picks one of five standard telecom test polynomials at run time. The three longer patterns are sent out inverted, as those patterns are defined. A load input, or any change of the mode input, forces the shared 31-bit state to all ones so the generator restarts from a known point and can never stall in the all-zero state. An enable input lets the sequence pause and resume without losing or repeating bits. A valid flag marks the words that were freshly produced.

Top module: `prbs_word_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `word` is all zeros and `valid` is low; the state starts as all ones.
- R2: Mode codes select the feedback polynomial: 0 gives x^7+x^6+1, 1 gives x^10+x^7+1, 2 gives x^15+x^14+1, 3 gives x^23+x^18+1, 4 gives x^31+x^28+1; codes 5, 6 and 7 behave as code 0.
- R3: The serial reference is a shift register of length N with new bit = s[N-1] xor s[T-1] shifted in at bit 0 and also emitted; on each advancing cycle `word` (one cycle later) holds the next WORD_W emitted bits, bit WORD_W-1 being the earliest.
- R4: For mode codes 2, 3 and 4 every emitted bit is inverted; for codes 0, 1 and 5 to 7 it is not.
- R5: A high `load` sets the state to all ones, takes priority over `enable`, leaves `word` unchanged and drives `valid` low in the next cycle.
- R6: Any change of the `mode` value from the previous cycle has the same effect as `load`.
- R7: With `enable` low (and no reseed), state and `word` hold, `valid` is low in the next cycle, and the sequence later resumes with no bit skipped or repeated.
- R8: `valid` is high exactly in the cycle after a cycle with `enable` high, `load` low and `mode` unchanged.
- R9: The output stream of modes 0 and 1 repeats after exactly 127 and 1023 bits with no shorter period, and for modes 0 to 2 a valid word is never all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance the sequence by one word |
| load | input | 1 | Reseed the state to all ones |
| mode | input | 3 | Polynomial select code |
| word | output | WORD_W | Registered pattern word, MSB earliest |
| valid | output | 1 | Word was produced in the previous cycle |

## Verification
The assertions assume the mode input is only read as a code and that any value on it, including the aliased codes 5 to 7, is legal, so they place no restriction on mode changes; they do assume that when a word is flagged valid, the mode value of the previous cycle was the one that produced it. The stimulus changes the mode only at the clock's falling edge and holds it for whole cycles, with load, enable and mode combinations driven in every order the reseed priority rules distinguish. The period sweeps keep load low and the mode constant for the whole run so the collected stream is one unbroken sequence.

// File: rtl/prbs_word_pkg.sv
package prbs_word_pkg;

  localparam int STATE_W   = 31;
  localparam int MODE_W    = 3;
  localparam int NUM_MODES = 5;

  typedef struct packed {
    logic reseed;
    logic advance;
  } genCtrl_t;

  function automatic int polyLen(input int m);
    case (m)
      1:       return 10;
      2:       return 15;
      3:       return 23;
      4:       return 31;
      default: return 7;
    endcase
  endfunction

  function automatic int polyTap(input int m);
    case (m)
      1:       return 7;
      2:       return 14;
      3:       return 18;
      4:       return 28;
      default: return 6;
    endcase
  endfunction

  function automatic logic polyInv(input int m);
    return (m >= 2);
  endfunction

endpackage

// File: rtl/prbs_ctrl.sv
module prbs_ctrl
  import prbs_word_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              load,
  input  logic [MODE_W-1:0] modeIn,
  output genCtrl_t          ctrl,
  output logic [MODE_W-1:0] modeIdx,
  output logic              validQ
);

  logic [MODE_W-1:0] prevMode;
  logic              modeChanged;

  assign modeChanged  = (modeIn != prevMode);
  assign ctrl.reseed  = load | modeChanged;
  assign ctrl.advance = enable & ~ctrl.reseed;
  assign modeIdx      = (modeIn < MODE_W'(NUM_MODES)) ? modeIn : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode <= '0;
      validQ   <= 1'b0;
    end else begin
      prevMode <= modeIn;
      validQ   <= ctrl.advance;
    end
  end

endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_word_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  genCtrl_t          ctrl,
  input  logic [MODE_W-1:0] modeIdx,
  output logic [WORD_W-1:0] wordQ
);

  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] candState [NUM_MODES];
  logic [WORD_W-1:0]  candWord  [NUM_MODES];
  logic [STATE_W-1:0] nextState;
  logic [WORD_W-1:0]  nextWord;

  for (genvar m = 0; m < NUM_MODES; m++) begin : g_mode
    localparam int   LEN = polyLen(m);
    localparam int   TAP = polyTap(m);
    localparam logic INV = polyInv(m);
    localparam logic [STATE_W-1:0] MASK = STATE_W'((64'd1 << LEN) - 64'd1);

    logic [STATE_W-1:0] stepState;
    logic [WORD_W-1:0]  stepWord;

    always_comb begin : stepper
      logic [STATE_W-1:0] walk;
      logic               fbBit;
      walk     = stateQ;
      fbBit    = 1'b0;
      stepWord = '0;
      for (int i = 0; i < WORD_W; i++) begin
        fbBit = walk[LEN-1] ^ walk[TAP-1];
        walk  = {walk[STATE_W-2:0], fbBit} & MASK;
        stepWord[WORD_W-1-i] = fbBit ^ INV;
      end
      stepState = walk;
    end

    assign candState[m] = stepState;
    assign candWord[m]  = stepWord;
  end

  always_comb begin
    case (modeIdx)
      3'd1:    begin nextState = candState[1]; nextWord = candWord[1]; end
      3'd2:    begin nextState = candState[2]; nextWord = candWord[2]; end
      3'd3:    begin nextState = candState[3]; nextWord = candWord[3]; end
      3'd4:    begin nextState = candState[4]; nextWord = candWord[4]; end
      default: begin nextState = candState[0]; nextWord = candWord[0]; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '1;
      wordQ  <= '0;
    end else if (ctrl.reseed) begin
      stateQ <= '1;
    end else if (ctrl.advance) begin
      stateQ <= nextState;
      wordQ  <= nextWord;
    end
  end

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_word_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              load,
  input  logic [2:0]        mode,
  output logic [WORD_W-1:0] word,
  output logic              valid
);

  genCtrl_t          ctrl;
  logic [MODE_W-1:0] modeIdx;

  prbs_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .enable  (enable),
    .load    (load),
    .modeIn  (mode),
    .ctrl    (ctrl),
    .modeIdx (modeIdx),
    .validQ  (valid)
  );

  prbs_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .modeIdx (modeIdx),
    .wordQ   (word)
  );

endmodule

// File: rtl/prbs_word_gen_chk.sv
module prbs_word_gen_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              load,
  input logic [2:0]        mode,
  input logic [WORD_W-1:0] word,
  input logic              valid
);

  AST_IDLE_HOLDS_WORD: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(word) && !valid)); // R7

  AST_LOAD_BLOCKS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    load |=> ($stable(word) && !valid)); // R5

  AST_MODE_SWITCH_RESEEDS: assert property (@(posedge clk) disable iff (!rstN)
    (mode != $past(mode)) |=> !valid); // R6

  AST_VALID_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> ($past(enable) && !$past(load))); // R8

  AST_NO_ZERO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    valid |-> ($past(mode) == 3'd3 || $past(mode) == 3'd4 || word != '0)); // R9

endmodule

bind prbs_word_gen prbs_word_gen_chk #(.WORD_W(WORD_W)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .enable (enable),
  .load   (load),
  .mode   (mode),
  .word   (word),
  .valid  (valid)
);

// File: tb/test_prbs_word_gen.sv
module test_prbs_word_gen;

  localparam int WORD_W = 16;
  localparam int MAX_BITS = 2200;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              load = 1'b0;
  logic [2:0]        mode = 3'd0;
  logic [WORD_W-1:0] word;
  logic              valid;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [31:0]       refState = 32'hFFFF_FFFF;
  logic [2:0]        refPrev = 3'd0;
  logic [WORD_W-1:0] expWord = '0;
  logic              expValid = 1'b0;

  logic streamBits [MAX_BITS];
  int   streamLen = 0;
  logic recording = 1'b0;

  always #2 clk = ~clk;

  prbs_word_gen #(.WORD_W(WORD_W)) i_prbs_word_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .load(load),
    .mode(mode), .word(word), .valid(valid)
  );

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        mismatched++;
        $display("FAIL watchdog: run did not finish, cycles %0d expected below 150000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    end
  end

  function automatic int lenOf(input logic [2:0] md);
    case (md)
      3'd1: return 10; 3'd2: return 15; 3'd3: return 23; 3'd4: return 31;
      default: return 7;
    endcase
  endfunction

  function automatic int tapOf(input logic [2:0] md);
    case (md)
      3'd1: return 7; 3'd2: return 14; 3'd3: return 18; 3'd4: return 28;
      default: return 6;
    endcase
  endfunction

  task automatic refClock(input logic e, input logic l, input logic [2:0] md);
    int n;
    int t;
    logic [31:0] msk;
    logic fb;
    logic inv;
    if (l || md != refPrev) begin
      refState = 32'hFFFF_FFFF;
      expValid = 1'b0;
    end else if (e) begin
      n   = lenOf(md);
      t   = tapOf(md);
      msk = (32'd1 << n) - 32'd1;
      inv = (md == 3'd2 || md == 3'd3 || md == 3'd4);
      for (int i = 0; i < WORD_W; i++) begin
        fb = refState[n-1] ^ refState[t-1];
        refState = ((refState << 1) | {31'd0, fb}) & msk;
        expWord[WORD_W-1-i] = fb ^ inv;
      end
      expValid = 1'b1;
    end else begin
      expValid = 1'b0;
    end
    refPrev = md;
  endtask

  task automatic check(input logic ok, input string tag, input string what);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: word=%h valid=%b, expected word=%h valid=%b",
               tag, what, word, valid, expWord, expValid);
    end
  endtask

  task automatic step(input logic e, input logic l, input logic [2:0] md, input string tag);
    enable = e;
    load   = l;
    mode   = md;
    @(posedge clk);
    refClock(e, l, md);
    @(negedge clk);
    check(word === expWord && valid === expValid, tag, "cycle compare");
    if (recording && valid) begin
      for (int i = WORD_W - 1; i >= 0; i--) begin
        if (streamLen < MAX_BITS) begin
          streamBits[streamLen] = word[i];
          streamLen++;
        end
      end
    end
  endtask

  task automatic checkPeriod(input int p, input string tag);
    logic same;
    logic differs;
    same = 1'b1;
    for (int i = 0; i + p < streamLen; i++)
      if (streamBits[i] !== streamBits[i+p]) same = 1'b0;
    compared++;
    if (!same) begin
      mismatched++;
      $display("FAIL %s: stream does not repeat after %0d bits, actual=0 expected=1", tag, p);
    end
    for (int d = 1; d < p; d++) begin
      if (p % d == 0) begin
        differs = 1'b0;
        for (int i = 0; i + d < streamLen; i++)
          if (streamBits[i] !== streamBits[i+d]) differs = 1'b1;
        compared++;
        if (!differs) begin
          mismatched++;
          $display("FAIL %s: stream repeats after %0d bits, actual=%0d expected=%0d", tag, d, d, p);
        end
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: outputs during reset
    check(word === '0 && valid === 1'b0, "R1", "in reset");
    rstN = 1'b1;
    @(negedge clk);
    check(word === '0 && valid === 1'b0, "R1", "after reset");

    // R3: first words from the reset state in mode 0
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 3'd0, "R3");

    // R2 R4: each polynomial after a load, with inversion where required
    for (int m = 0; m < 5; m++) begin
      step(1'b0, 1'b1, 3'(m), "R5");
      for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 3'(m), (m >= 2) ? "R4" : "R2");
    end

    // R7: pause and resume in mode 4
    for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 3'd4, "R7");
    for (int k = 0; k < 6; k++) step(1'b1, 1'b0, 3'd4, "R7");
    step(1'b0, 1'b0, 3'd4, "R7");
    step(1'b1, 1'b0, 3'd4, "R7");

    // R6: mode change while running reseeds
    step(1'b1, 1'b0, 3'd2, "R6");
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 3'd2, "R6");
    step(1'b1, 1'b0, 3'd3, "R6");
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 3'd3, "R6");

    // R5: load wins over enable mid-run
    step(1'b1, 1'b1, 3'd3, "R5");
    step(1'b1, 1'b1, 3'd3, "R5");
    for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 3'd3, "R5");

    // R2: aliased codes behave as code 0
    for (int c = 5; c < 8; c++) begin
      step(1'b1, 1'b0, 3'(c), "R2");
      for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 3'(c), "R2");
    end

    // R8: alternating enable
    for (int k = 0; k < 12; k++) step(k[0], 1'b0, 3'd1, "R8");

    // R9: periods of the two short modes
    step(1'b0, 1'b1, 3'd0, "R9");
    streamLen = 0;
    recording = 1'b1;
    for (int k = 0; k < 20; k++) step(1'b1, 1'b0, 3'd0, "R9");
    recording = 1'b0;
    checkPeriod(127, "R9 mode0");

    step(1'b0, 1'b1, 3'd1, "R9");
    streamLen = 0;
    recording = 1'b1;
    for (int k = 0; k < 136; k++) step(1'b1, 1'b0, 3'd1, "R9");
    recording = 1'b0;
    checkPeriod(1023, "R9 mode1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule